// File: doc/BRIEF.md
# Pixel Offset and Digital Gain Corrector

This block applies per-pixel digital correction to 12-bit converter samples in a three-colour imaging front end. Each accepted sample first has a programmable offset constant added and a per-pixel offset subtracted. The difference is then multiplied by a digital gain and limited to the 12-bit output range. A channel tag travels with each sample and comes out alongside the corrected result.

The gain is one plus a fraction. The fraction is an unsigned 12-bit gain code, scaled by a multiplier X and divided by 4096. A three-bit one-hot range field picks X from 1, 3 or 7, so the largest gain is just under 2, 4 or 8. A code of zero always gives unity gain. The same range field applies to every channel.

The datapath has two register stages: one for the offset step and one for the multiply and clamp. A sample therefore appears on the output two clock edges after it is accepted. All inputs (offsets, gain code and range field) are sampled on the same edge as the sample.

Top module: `ds_corrector`

## Requirements
- R1: With a gain code of 0, the output equals `in_sample + ofs_const - ofs_pixel` whenever that value lies in 0..4095.
- R2: When `in_sample + ofs_const - ofs_pixel` is negative, the output is 0, whatever the gain code is.
- R3: With a non-negative difference D, the output is floor((D·4096 + D·code·X) / 4096), clamped at 4095. The output is never below min(D, 4095).
- R4: `range_sel` is one-hot: 3'b001 gives X=1, 3'b010 gives X=3 and 3'b100 gives X=7.
- R5: Any other `range_sel` pattern (000, 011, 101, 110, 111) behaves exactly like X=1.
- R6: Any result above 4095, including any D above 4095, is output as 4095.
- R7: `out_valid` is high exactly two rising edges after `in_valid` was sampled high, and low otherwise. `out_chan` carries that sample's `in_chan`.
- R8: A synchronous active-high `rst` clears both pipeline valid flags, so `out_valid` is low on the cycles that follow reset.
- R9: The channel tag has no effect on the arithmetic: the same inputs on channels 0, 1 and 2 give the same output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 2 | Colour channel tag of the sample |
| in_sample | input | 12 | Unsigned converter sample |
| ofs_const | input | 8 | Unsigned offset constant, added |
| ofs_pixel | input | 8 | Unsigned per-pixel offset, subtracted |
| gain_code | input | 12 | Unsigned fractional gain code |
| range_sel | input | 3 | One-hot gain range select |
| out_valid | output | 1 | Corrected sample valid |
| out_chan | output | 2 | Channel tag of the corrected sample |
| out_data | output | 12 | Corrected, clamped sample |

## Verification
The hardest case to reach is the one where a full-scale sample plus the offset constant goes past 4095 before any gain is applied. Saturation then has to come from the offset step alone, at unity gain. Random stimulus rarely lines up a near-full-scale sample, a large added offset, a small subtracted offset and a zero code all at once. Directed vectors therefore pin those values. The random phase also draws its samples from a mix biased toward both ends of the range, so that both clamp paths and the truncation of the fractional product are hit often.

// File: rtl/ds_corr_pkg.sv
package ds_corr_pkg;
  localparam int DEF_DATA_W  = 12;
  localparam int DEF_OFS_W   = 8;
  localparam int DEF_CODE_W  = 12;
  localparam int DEF_CHAN_W  = 2;
  localparam int RANGE_W     = 3;
  localparam int XMUL_W      = 3;

  // One-hot range field to gain multiplier; illegal patterns fall back to 1.
  function automatic logic [XMUL_W-1:0] range_to_xmul(input logic [RANGE_W-1:0] sel);
    logic [XMUL_W-1:0] x;
    unique case (sel)
      3'b001:  x = 3'd1;
      3'b010:  x = 3'd3;
      3'b100:  x = 3'd7;
      default: x = 3'd1;
    endcase
    return x;
  endfunction
endpackage

// File: rtl/ds_range_decode.sv
module ds_range_decode
  import ds_corr_pkg::*;
(
  input  logic [RANGE_W-1:0] range_sel,
  output logic [XMUL_W-1:0]  xmul
);
  always_comb xmul = range_to_xmul(range_sel);
endmodule

// File: rtl/ds_offset_stage.sv
module ds_offset_stage
  import ds_corr_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int OFS_W  = DEF_OFS_W,
  parameter int CODE_W = DEF_CODE_W,
  parameter int CHAN_W = DEF_CHAN_W,
  localparam int DW    = (DATA_W > OFS_W ? DATA_W : OFS_W) + 1,
  localparam int SW    = DW + 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [OFS_W-1:0]  ofs_const,
  input  logic [OFS_W-1:0]  ofs_pixel,
  input  logic [CODE_W-1:0] gain_code,
  input  logic [XMUL_W-1:0] xmul_in,
  output logic              s1_valid,
  output logic [CHAN_W-1:0] s1_chan,
  output logic [DW-1:0]     s1_diff,
  output logic              s1_zero,
  output logic [CODE_W-1:0] s1_code,
  output logic [XMUL_W-1:0] s1_xmul
);
  // Signed difference: sample plus constant minus per-pixel offset.
  function automatic logic signed [SW-1:0] offset_diff(
    input logic [DATA_W-1:0] smp,
    input logic [OFS_W-1:0]  addend,
    input logic [OFS_W-1:0]  subtrahend
  );
    logic signed [SW-1:0] a, b, c;
    a = $signed(SW'(smp));
    b = $signed(SW'(addend));
    c = $signed(SW'(subtrahend));
    return a + b - c;
  endfunction

  logic signed [SW-1:0] raw_diff;
  logic                 neg_evt;
  logic [DW-1:0]        clipped;

  always_comb begin
    raw_diff = offset_diff(in_sample, ofs_const, ofs_pixel);
    neg_evt  = raw_diff[SW-1];
    clipped  = neg_evt ? '0 : raw_diff[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_chan <= in_chan;
      s1_diff <= clipped;
      s1_zero <= neg_evt;
      s1_code <= gain_code;
      s1_xmul <= xmul_in;
    end
  end
endmodule

// File: rtl/ds_gain_stage.sv
module ds_gain_stage
  import ds_corr_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int OFS_W  = DEF_OFS_W,
  parameter int CODE_W = DEF_CODE_W,
  parameter int CHAN_W = DEF_CHAN_W,
  localparam int DW    = (DATA_W > OFS_W ? DATA_W : OFS_W) + 1,
  localparam int FRAC_W = DATA_W,
  localparam int PW    = DW + CODE_W + XMUL_W + 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic [CHAN_W-1:0] s1_chan,
  input  logic [DW-1:0]     s1_diff,
  input  logic [CODE_W-1:0] s1_code,
  input  logic [XMUL_W-1:0] s1_xmul,
  output logic              out_valid,
  output logic [CHAN_W-1:0] out_chan,
  output logic [DATA_W-1:0] out_data
);
  // Full-precision diff * (1 + code*X / 2^FRAC_W), truncated, then clamped.
  function automatic logic [DATA_W-1:0] scale_and_clamp(
    input logic [DW-1:0]     d,
    input logic [CODE_W-1:0] code,
    input logic [XMUL_W-1:0] x
  );
    logic [PW-1:0] unity_part, frac_part, total, shifted;
    unity_part = PW'(d) << FRAC_W;
    frac_part  = PW'(d) * PW'(code) * PW'(x);
    total      = unity_part + frac_part;
    shifted    = total >> FRAC_W;
    if (|shifted[PW-1:DATA_W]) return '1;
    return shifted[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] scaled;
  always_comb scaled = scale_and_clamp(s1_diff, s1_code, s1_xmul);

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      out_chan <= s1_chan;
      out_data <= scaled;
    end
  end
endmodule

// File: rtl/ds_corrector.sv
module ds_corrector
  import ds_corr_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int OFS_W  = DEF_OFS_W,
  parameter int CODE_W = DEF_CODE_W,
  parameter int CHAN_W = DEF_CHAN_W,
  localparam int DW    = (DATA_W > OFS_W ? DATA_W : OFS_W) + 1
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [CHAN_W-1:0]  in_chan,
  input  logic [DATA_W-1:0]  in_sample,
  input  logic [OFS_W-1:0]   ofs_const,
  input  logic [OFS_W-1:0]   ofs_pixel,
  input  logic [CODE_W-1:0]  gain_code,
  input  logic [RANGE_W-1:0] range_sel,
  output logic               out_valid,
  output logic [CHAN_W-1:0]  out_chan,
  output logic [DATA_W-1:0]  out_data
);
  // Named inter-stage signals, also observed by the bound checker.
  logic [XMUL_W-1:0] xmul_in;
  logic              s1_valid;
  logic [CHAN_W-1:0] s1_chan;
  logic [DW-1:0]     s1_diff;
  logic              s1_zero;
  logic [CODE_W-1:0] s1_code;
  logic [XMUL_W-1:0] s1_xmul;

  ds_range_decode u_range (
    .range_sel (range_sel),
    .xmul      (xmul_in)
  );

  ds_offset_stage #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .CODE_W(CODE_W), .CHAN_W(CHAN_W)
  ) u_ofs (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .in_sample (in_sample),
    .ofs_const (ofs_const),
    .ofs_pixel (ofs_pixel),
    .gain_code (gain_code),
    .xmul_in   (xmul_in),
    .s1_valid  (s1_valid),
    .s1_chan   (s1_chan),
    .s1_diff   (s1_diff),
    .s1_zero   (s1_zero),
    .s1_code   (s1_code),
    .s1_xmul   (s1_xmul)
  );

  ds_gain_stage #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .CODE_W(CODE_W), .CHAN_W(CHAN_W)
  ) u_gain (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1_chan   (s1_chan),
    .s1_diff   (s1_diff),
    .s1_code   (s1_code),
    .s1_xmul   (s1_xmul),
    .out_valid (out_valid),
    .out_chan  (out_chan),
    .out_data  (out_data)
  );
endmodule

// File: rtl/ds_corrector_chk.sv
module ds_corrector_chk
  import ds_corr_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int OFS_W  = DEF_OFS_W,
  parameter int CODE_W = DEF_CODE_W,
  parameter int CHAN_W = DEF_CHAN_W,
  localparam int DW    = (DATA_W > OFS_W ? DATA_W : OFS_W) + 1,
  localparam logic [DW-1:0] FULL = DW'((1 << DATA_W) - 1)
)(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [CHAN_W-1:0] in_chan,
  input logic              s1_valid,
  input logic [CHAN_W-1:0] s1_chan,
  input logic [DW-1:0]     s1_diff,
  input logic              s1_zero,
  input logic [CODE_W-1:0] s1_code,
  input logic [XMUL_W-1:0] s1_xmul,
  input logic              out_valid,
  input logic [CHAN_W-1:0] out_chan,
  input logic [DATA_W-1:0] out_data
);
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!s1_valid && !out_valid));

  assert_valid_s1_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);
  assert_idle_s1_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !s1_valid);
  assert_valid_out_R7: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);
  assert_idle_out_R7: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> !out_valid);
  assert_chan_s1_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (s1_chan == $past(in_chan)));
  assert_chan_out_R7: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> (out_chan == $past(s1_chan)));

  assert_neg_to_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_zero) |=> (out_data == '0));

  assert_unity_gain_R1: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_code == '0 && s1_diff <= FULL) |=>
      (out_data == $past(s1_diff[DATA_W-1:0])));

  assert_gain_floor_R3: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_diff <= FULL) |=> (out_data >= $past(s1_diff[DATA_W-1:0])));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_diff > FULL) |=> (out_data == '1));

  assert_legal_mult_R5: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> (s1_xmul == 3'd1 || s1_xmul == 3'd3 || s1_xmul == 3'd7));
endmodule

bind ds_corrector ds_corrector_chk #(
  .DATA_W(DATA_W), .OFS_W(OFS_W), .CODE_W(CODE_W), .CHAN_W(CHAN_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_chan   (in_chan),
  .s1_valid  (s1_valid),
  .s1_chan   (s1_chan),
  .s1_diff   (s1_diff),
  .s1_zero   (s1_zero),
  .s1_code   (s1_code),
  .s1_xmul   (s1_xmul),
  .out_valid (out_valid),
  .out_chan  (out_chan),
  .out_data  (out_data)
);

// File: tb/ds_corrector_bench.sv
`timescale 1ns/1ps
module ds_corrector_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  in_chan;
  logic [11:0] in_sample;
  logic [7:0]  ofs_const;
  logic [7:0]  ofs_pixel;
  logic [11:0] gain_code;
  logic [2:0]  range_sel;
  logic        out_valid;
  logic [1:0]  out_chan;
  logic [11:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ds_corrector u_ds_corrector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_sample(in_sample), .ofs_const(ofs_const), .ofs_pixel(ofs_pixel),
    .gain_code(gain_code), .range_sel(range_sel),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
  );

  // Bench model of the correction, written from the requirements.
  function automatic int model(int smp, int oc, int op, int code, int rng);
    longint d, mult, num;
    d = smp + oc - op;
    if (d < 0) return 0;                           // R2
    case (rng)                                     // R4 / R5
      1: mult = 1;
      2: mult = 3;
      4: mult = 7;
      default: mult = 1;
    endcase
    num = d * (4096 + code * mult);                // R3
    num = num / 4096;
    if (num > 4095) num = 4095;                    // R6
    return int'(num);
  endfunction

  // Two-slot expectation pipeline, matching the two register stages.
  bit    pv[2];
  int    pd[2];
  int    pc[2];
  string pt[2];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: check outputs for the sample driven two steps earlier, then drive.
  task automatic step(bit v, int ch, int smp, int oc, int op, int code, int rng, string tag);
    check(out_valid == pv[1], pv[1] ? pt[1] : "R7", "out_valid", out_valid, pv[1]);
    if (pv[1] && out_valid) begin
      check(out_data == pd[1], pt[1], "out_data", out_data, pd[1]);
      check(out_chan == pc[1], "R7", "out_chan", out_chan, pc[1]);
    end
    pv[1] = pv[0]; pd[1] = pd[0]; pc[1] = pc[0]; pt[1] = pt[0];
    pv[0] = v;
    pd[0] = model(smp, oc, op, code, rng);
    pc[0] = ch;
    pt[0] = tag;
    in_valid  = v;
    in_chan   = 2'(ch);
    in_sample = 12'(smp);
    ofs_const = 8'(oc);
    ofs_pixel = 8'(op);
    gain_code = 12'(code);
    range_sel = 3'(rng);
    @(negedge clk);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 1, "R7");
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    pv[0] = 0; pv[1] = 0;
    rst = 1; in_valid = 0; in_chan = 0; in_sample = 0;
    ofs_const = 0; ofs_pixel = 0; gain_code = 0; range_sel = 3'b001;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    rst = 0;
    @(negedge clk);

    // R1: unity gain, offset step only
    step(1, 0, 1000, 20, 5, 0, 1, "R1");
    step(1, 1, 0, 0, 0, 0, 2, "R1");
    step(1, 2, 4000, 95, 0, 0, 4, "R1");
    // R2: negative difference clamps to zero even at full gain
    step(1, 0, 3, 0, 200, 4095, 4, "R2");
    step(1, 1, 0, 0, 1, 100, 1, "R2");
    // R3: truncation of the fractional product
    step(1, 2, 100, 0, 0, 2048, 1, "R3");
    step(1, 0, 3, 0, 0, 1365, 2, "R3");
    step(1, 1, 1, 0, 0, 4095, 4, "R3");
    // R4: each legal range with the same data
    step(1, 0, 500, 0, 0, 4095, 1, "R4");
    step(1, 0, 500, 0, 0, 4095, 2, "R4");
    step(1, 0, 500, 0, 0, 4095, 4, "R4");
    // R5: illegal range patterns behave as X=1
    step(1, 1, 500, 0, 0, 4095, 0, "R5");
    step(1, 1, 500, 0, 0, 4095, 3, "R5");
    step(1, 1, 500, 0, 0, 4095, 7, "R5");
    step(1, 1, 500, 0, 0, 4095, 6, "R5");
    // R6: saturation from gain and from the offset step alone
    step(1, 2, 4000, 0, 0, 4095, 4, "R6");
    step(1, 2, 4095, 255, 0, 0, 1, "R6");
    step(1, 2, 4090, 10, 4, 0, 1, "R6");
    // R9: same inputs on every channel
    for (int c = 0; c < 3; c++) step(1, c, 1234, 17, 9, 777, 2, "R9");
    // R7: gaps in the valid strobe
    step(0, 3, 999, 0, 0, 0, 1, "R7");
    step(1, 3, 321, 0, 0, 0, 1, "R7");
    step(0, 0, 888, 0, 0, 0, 1, "R7");
    flush();

    // R8: reset while samples are in flight
    step(1, 1, 700, 0, 0, 100, 1, "R8");
    step(1, 2, 800, 0, 0, 100, 1, "R8");
    rst = 1; in_valid = 0;
    @(negedge clk);
    rst = 0;
    pv[0] = 0; pv[1] = 0;
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid after reset+1", out_valid, 0);

    // Random phase, biased toward the ends of the range
    seed = $urandom(32'h5EED_1234);
    for (int i = 0; i < 400; i++) begin
      int smp, rng, code;
      int pick = $urandom_range(0, 3);
      smp = (pick == 0) ? $urandom_range(0, 60) :
            (pick == 1) ? $urandom_range(4000, 4095) : $urandom_range(0, 4095);
      code = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(0, 4095);
      rng  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : (1 << $urandom_range(0, 2));
      step($urandom_range(0, 4) != 0, $urandom_range(0, 2), smp,
           $urandom_range(0, 255), $urandom_range(0, 255), code, rng, "R3");
    end
    flush();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule